// File: doc/BRIEF.md
# Packet Frame Builder and Checker

This block turns a payload held in a 16-bit-wide packet buffer into a serial byte frame, and parses frames of the same shape arriving from the other direction. On the transmit side, control logic gives a payload length and a start strobe. The framer sends a run of zero bytes as a training pattern, then a delimiter, then a length byte, then the payload read from the buffer, then a 16-bit check sequence. It computes the check sequence while the payload goes out. A one-cycle completion pulse follows the last check byte.

On the receive side, the checker skips bytes until it sees the delimiter. It then takes the length byte, packs the payload back into 16-bit buffer words, and recomputes the check sequence. When the whole frame is in, it pulses a completion flag together with a match result and the payload length.

The outgoing stream uses valid/ready. The framer holds `tx_valid` and `tx_data` steady until the consumer raises `tx_ready`. Each byte is taken on a clock edge where both are high, and the sink may stall for any number of cycles. The incoming stream is never stalled, so `rx_ready` stays high and every cycle with `rx_valid` high delivers one byte.

Top module: `pkt_frame_engine`

## Requirements
- R1: The transmit frame is four bytes of 0x00, then the delimiter 0xA7, then a length byte equal to payload length plus 2, then the payload, then the check sequence low byte, then its high byte.
- R2: Payload byte i is read from buffer word i/2 (`tx_rd_addr`), from bits 7:0 when i is even and from bits 15:8 when i is odd. A final odd byte uses only the low half. The read port is asynchronous.
- R3: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, initial value 0x0000. Each byte is processed least significant bit first, which is the right-shifting register with constant 0x8408. It covers the payload bytes only.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold their values. The frame advances only on a handshake.
- R5: `tx_done` is high for exactly one cycle, the cycle after the handshake of the final check byte, and at no other time.
- R6: `tx_start` is ignored while a frame is being sent, and also when `tx_len` exceeds 125.
- R7: A zero-length payload gives a frame with length byte 0x02 and check bytes 0x00, 0x00.
- R8: The receiver discards every byte before the delimiter 0xA7. A length byte outside 2..127 returns it to delimiter search without raising `rx_done`.
- R9: The receiver writes payload bytes 2k and 2k+1 to word k as {byte 2k+1, byte 2k}. A final odd byte is written as {0x00, byte}. `rx_wr_en` pulses in the cycle after the byte that completes a word.
- R10: `rx_done` pulses one cycle after the second check byte is accepted. At that point `rx_crc_ok` is 1 exactly when the received check bytes (low byte first) equal the recomputed CRC, and `rx_len` gives the payload length. Both hold until the next `rx_done`.
- R11: After reset, `tx_valid`, `tx_done`, `rx_done`, `rx_wr_en` and `rx_crc_ok` are 0, and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Start strobe for a transmit frame |
| tx_len | input | 7 | Payload length in bytes, 0..125 |
| tx_rd_addr | output | 6 | Transmit buffer word address |
| tx_rd_data | input | 16 | Transmit buffer word read data |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Outgoing byte accepted by sink |
| tx_done | output | 1 | Transmit frame complete pulse |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Receiver can accept (always high) |
| rx_wr_en | output | 1 | Receive buffer write strobe |
| rx_wr_addr | output | 6 | Receive buffer word address |
| rx_wr_data | output | 16 | Receive buffer word data |
| rx_done | output | 1 | Receive frame complete pulse |
| rx_crc_ok | output | 1 | Check sequence of last frame matched |
| rx_len | output | 7 | Payload length of last frame |

## Verification
Transmit bytes appear combinationally in the cycle they are offered. The bench samples at the falling edge and scores a byte only when valid and ready are both high, since that byte is consumed at the next rising edge. `tx_done` is due at the falling edge one full cycle after the last check byte was scored, and the bench checks it there and expects it low everywhere else. `rx_wr_en` and `rx_done` are registered, so each is expected at the falling edge that follows the rising edge accepting the completing byte. The receive checks read the captured words and flags a few cycles later.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam logic [7:0] FRM_DELIM = 8'hA7;
  localparam logic [7:0] FRM_TRAIN = 8'h00;

  // reflected CRC-16 (x^16+x^12+x^5+1), one byte, LSB first
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ b[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction
endpackage

// File: rtl/frm_tx.sv
module frm_tx import frm_pkg::*; #(
  parameter int AW   = 6,
  parameter int MAXP = 125,
  parameter int PREN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [$clog2(MAXP+1)-1:0]    len,
  output logic [AW-1:0]                rd_addr,
  input  logic [15:0]                  rd_data,
  output logic                         valid,
  output logic [7:0]                   data,
  input  logic                         ready,
  output logic                         done
);
  localparam int LW   = $clog2(MAXP+1);
  localparam int MAXW = (MAXP-1)/2;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_DLM, S_LEN, S_PAY, S_FLO, S_FHI} st_e;
  st_e            st;
  logic [LW-1:0]  cnt, len_q;
  logic [15:0]    crc_q;
  logic           fire;

  assign valid   = (st != S_IDLE);
  assign fire    = valid && ready;
  assign rd_addr = AW'(cnt >> 1);

  always_comb begin
    case (st)
      S_PRE:   data = FRM_TRAIN;
      S_DLM:   data = FRM_DELIM;
      S_LEN:   data = 8'(len_q) + 8'd2;
      S_PAY:   data = cnt[0] ? rd_data[15:8] : rd_data[7:0];
      S_FLO:   data = crc_q[7:0];
      S_FHI:   data = crc_q[15:8];
      default: data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; len_q <= '0; crc_q <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start && len <= LW'(MAXP)) begin
          len_q <= len; cnt <= '0; crc_q <= '0; st <= S_PRE;
        end
        S_PRE: if (fire) begin
          if (cnt == LW'(PREN-1)) begin cnt <= '0; st <= S_DLM; end
          else cnt <= cnt + 1'b1;
        end
        S_DLM: if (fire) st <= S_LEN;
        S_LEN: if (fire) begin
          cnt <= '0;
          st  <= (len_q == '0) ? S_FLO : S_PAY;
        end
        S_PAY: if (fire) begin
          crc_q <= crc16_byte(crc_q, data);
          if (cnt == LW'(len_q - 1'b1)) st <= S_FLO;
          else cnt <= cnt + 1'b1;
        end
        S_FLO: if (fire) st <= S_FHI;
        S_FHI: if (fire) begin st <= S_IDLE; done <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4: offered byte holds under back-pressure
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data));
  // R5: completion is a single-cycle pulse with the stream idle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid ##1 !done);
  // R2: payload reads stay inside the buffer
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAY) |-> rd_addr <= AW'(MAXW));
endmodule

// File: rtl/frm_rx.sv
module frm_rx import frm_pkg::*; #(
  parameter int AW   = 6,
  parameter int MAXP = 125
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         valid,
  input  logic [7:0]                   data,
  output logic                         ready,
  output logic                         wr_en,
  output logic [AW-1:0]                wr_addr,
  output logic [15:0]                  wr_data,
  output logic                         done,
  output logic                         crc_ok,
  output logic [$clog2(MAXP+1)-1:0]    len_out
);
  localparam int LW   = $clog2(MAXP+1);
  localparam int MAXW = (MAXP-1)/2;

  typedef enum logic [2:0] {R_HUNT, R_LEN, R_PAY, R_FLO, R_FHI} st_e;
  st_e            st;
  logic [LW-1:0]  cnt, len_q;
  logic [15:0]    crc_q;
  logic [7:0]     lo_hold, fcs_lo;
  logic           last;

  assign ready = 1'b1;
  assign last  = (cnt == LW'(len_q - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= R_HUNT; cnt <= '0; len_q <= '0; crc_q <= '0;
      lo_hold <= '0; fcs_lo <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      done <= 1'b0; crc_ok <= 1'b0; len_out <= '0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (valid) begin
        case (st)
          R_HUNT: if (data == FRM_DELIM) st <= R_LEN;
          R_LEN: begin
            if (data >= 8'd2 && data <= 8'(MAXP+2)) begin
              len_q <= LW'(data - 8'd2);
              cnt   <= '0;
              crc_q <= '0;
              st    <= (data == 8'd2) ? R_FLO : R_PAY;
            end else begin
              st <= R_HUNT;
            end
          end
          R_PAY: begin
            crc_q <= crc16_byte(crc_q, data);
            if (!cnt[0]) lo_hold <= data;
            if (cnt[0]) begin
              wr_en <= 1'b1; wr_addr <= AW'(cnt >> 1); wr_data <= {data, lo_hold};
            end else if (last) begin
              wr_en <= 1'b1; wr_addr <= AW'(cnt >> 1); wr_data <= {8'h00, data};
            end
            if (last) st <= R_FLO;
            else cnt <= cnt + 1'b1;
          end
          R_FLO: begin fcs_lo <= data; st <= R_FHI; end
          R_FHI: begin
            done    <= 1'b1;
            crc_ok  <= ({data, fcs_lo} == crc_q);
            len_out <= len_q;
            st      <= R_HUNT;
          end
          default: st <= R_HUNT;
        endcase
      end
    end
  end

  // R9: writes stay inside the buffer
  a_r9_wr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr <= AW'(MAXW));
  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: result and length only change together with completion
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(len_out) || done);
  // R11: receiver never stalls
  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n) ready);
endmodule

// File: rtl/pkt_frame_engine.sv
module pkt_frame_engine #(
  parameter int AW   = 6,
  parameter int MAXP = 125,
  parameter int PREN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tx_start,
  input  logic [$clog2(MAXP+1)-1:0]  tx_len,
  output logic [AW-1:0]              tx_rd_addr,
  input  logic [15:0]                tx_rd_data,
  output logic                       tx_valid,
  output logic [7:0]                 tx_data,
  input  logic                       tx_ready,
  output logic                       tx_done,
  input  logic                       rx_valid,
  input  logic [7:0]                 rx_data,
  output logic                       rx_ready,
  output logic                       rx_wr_en,
  output logic [AW-1:0]              rx_wr_addr,
  output logic [15:0]                rx_wr_data,
  output logic                       rx_done,
  output logic                       rx_crc_ok,
  output logic [$clog2(MAXP+1)-1:0]  rx_len
);
  frm_tx #(.AW(AW), .MAXP(MAXP), .PREN(PREN)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .len(tx_len),
    .rd_addr(tx_rd_addr), .rd_data(tx_rd_data),
    .valid(tx_valid), .data(tx_data), .ready(tx_ready), .done(tx_done));

  frm_rx #(.AW(AW), .MAXP(MAXP)) u_rx (
    .clk(clk), .rst_n(rst_n), .valid(rx_valid), .data(rx_data), .ready(rx_ready),
    .wr_en(rx_wr_en), .wr_addr(rx_wr_addr), .wr_data(rx_wr_data),
    .done(rx_done), .crc_ok(rx_crc_ok), .len_out(rx_len));
endmodule

// File: tb/pkt_frame_engine_tb_top.sv
`timescale 1ns/1ps
module pkt_frame_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        tx_start = 1'b0;
  logic [6:0]  tx_len = '0;
  logic [5:0]  tx_rd_addr;
  logic [15:0] tx_rd_data;
  logic        tx_valid, tx_done;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, rx_wr_en, rx_done, rx_crc_ok;
  logic [5:0]  rx_wr_addr;
  logic [15:0] rx_wr_data;
  logic [6:0]  rx_len;

  logic [15:0] txmem [64];
  logic [15:0] rxmem [64];
  assign tx_rd_data = txmem[tx_rd_addr];

  pkt_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_len(tx_len),
    .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_wr_en(rx_wr_en), .rx_wr_addr(rx_wr_addr), .rx_wr_data(rx_wr_data),
    .rx_done(rx_done), .rx_crc_ok(rx_crc_ok), .rx_len(rx_len));

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  bit         last_q[$];
  int tx_done_cnt = 0;
  int rx_done_cnt = 0;
  logic       rx_ok_cap = 1'b0;
  logic [6:0] rx_len_cap = '0;
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5B;

  // R3 reference: bit-serial CRC written with the normal (0x1021) register on
  // reversed bits, then reversed back
  function automatic logic [15:0] ref_crc(input logic [7:0] bytes[$]);
    logic [15:0] r = 16'h0000;
    logic [15:0] o;
    foreach (bytes[k]) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = r[15] ^ bytes[k][i];
        r = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h1021;
      end
    end
    for (int i = 0; i < 16; i++) o[i] = r[15-i];
    return o;
  endfunction

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 5) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern for back-pressure (R4)
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // monitor: scoreboard for tx stream, done timing, hold, rx capture
  bit         exp_done = 1'b0;
  bit         prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_done) begin
        chk(tx_done === 1'b1, "R5 done after last byte", tx_done, 1);
        exp_done = 1'b0;
      end else if (tx_done === 1'b1) begin
        chk(1'b0, "R5 spurious done", 1, 0);
      end
      if (tx_done === 1'b1) tx_done_cnt++;
      if (prev_stall)
        chk(tx_valid === 1'b1 && tx_data === prev_data, "R4 hold under stall", tx_data, prev_data);
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1/R6 unexpected byte", tx_data, 0);
        end else begin
          logic [7:0] e;
          bit l;
          e = exp_q.pop_front();
          l = last_q.pop_front();
          chk(tx_data === e, "R1 R2 R3 tx byte", tx_data, e);
          if (l) exp_done = 1'b1;
        end
      end
      if (rx_wr_en) rxmem[rx_wr_addr] = rx_wr_data;
      if (rx_done) begin
        rx_done_cnt++;
        rx_ok_cap  = rx_crc_ok;
        rx_len_cap = rx_len;
      end
    end
  end

  task automatic tx_frame(input int n, input int seed, input bit poke);
    logic [7:0] pay[$];
    logic [15:0] c;
    int d0;
    for (int i = 0; i < n; i++) pay.push_back(pat(i, seed));
    for (int w = 0; w < 64; w++) txmem[w] = 16'hBEEF;
    for (int i = 0; i < n; i++)
      if (i % 2 == 0) txmem[i/2][7:0] = pay[i]; else txmem[i/2][15:8] = pay[i];
    c = ref_crc(pay);
    for (int i = 0; i < 4; i++) begin exp_q.push_back(8'h00); last_q.push_back(1'b0); end
    exp_q.push_back(8'hA7); last_q.push_back(1'b0);
    exp_q.push_back(8'(n + 2)); last_q.push_back(1'b0);
    foreach (pay[i]) begin exp_q.push_back(pay[i]); last_q.push_back(1'b0); end
    exp_q.push_back(c[7:0]); last_q.push_back(1'b0);
    exp_q.push_back(c[15:8]); last_q.push_back(1'b1);
    d0 = tx_done_cnt;
    @(posedge clk); #1; tx_start = 1'b1; tx_len = 7'(n);
    @(posedge clk); #1; tx_start = 1'b0;
    if (poke) begin  // R6: start during a frame must be ignored
      repeat (5) @(posedge clk);
      #1; tx_start = 1'b1; tx_len = 7'd3;
      @(posedge clk); #1; tx_start = 1'b0;
    end
    while (tx_done_cnt == d0) @(posedge clk);
    repeat (12) @(posedge clk);
    chk(exp_q.size() == 0 && tx_done_cnt == d0 + 1, "R5 R6 one frame one done",
        tx_done_cnt - d0, 1);
    @(negedge clk);
    chk(tx_valid === 1'b0, "R6 idle after frame", tx_valid, 0);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(posedge clk); #1; rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1; rx_valid = 1'b0;
  endtask

  task automatic rx_frame(input int n, input int seed, input bit bad, input int junk);
    logic [7:0] pay[$];
    logic [15:0] c;
    int d0;
    for (int i = 0; i < n; i++) pay.push_back(pat(i, seed));
    c = ref_crc(pay);
    if (bad) c = c ^ 16'h0100;
    for (int w = 0; w < 64; w++) rxmem[w] = 16'hDEAD;
    d0 = rx_done_cnt;
    for (int j = 0; j < junk; j++) rx_byte(8'(8'h3C + j));
    for (int j = 0; j < 4; j++) rx_byte(8'h00);
    rx_byte(8'hA7);
    rx_byte(8'(n + 2));
    foreach (pay[i]) rx_byte(pay[i]);
    rx_byte(c[7:0]);
    rx_byte(c[15:8]);
    repeat (3) @(posedge clk);
    chk(rx_done_cnt == d0 + 1, "R10 rx done count", rx_done_cnt - d0, 1);
    chk(rx_ok_cap === !bad, "R10 crc_ok", rx_ok_cap, !bad);
    chk(rx_len_cap === 7'(n), "R10 rx_len", rx_len_cap, n);
    for (int w = 0; w < (n + 1) / 2; w++) begin
      logic [15:0] e;
      e = {(2*w+1 < n) ? pay[2*w+1] : 8'h00, pay[2*w]};
      chk(rxmem[w] === e, "R9 stored word", rxmem[w], e);
    end
    chk(rxmem[(n + 1) / 2] === 16'hDEAD, "R9 no extra write", rxmem[(n+1)/2], 16'hDEAD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) txmem[w] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(tx_valid === 1'b0 && tx_done === 1'b0, "R11 tx reset", tx_valid, 0);
    chk(rx_done === 1'b0 && rx_wr_en === 1'b0 && rx_crc_ok === 1'b0, "R11 rx reset", rx_done, 0);
    chk(rx_ready === 1'b1, "R11 rx_ready", rx_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    tx_frame(5, 1, 1'b0);      // R1 R2 odd length
    tx_frame(4, 2, 1'b0);      // R2 even length
    tx_frame(0, 3, 1'b0);      // R7 empty payload
    stall_en = 1'b1;
    tx_frame(125, 4, 1'b1);    // R4 back-pressure, R6 start while busy, max length
    tx_frame(9, 5, 1'b0);
    stall_en = 1'b0;
    // R6 over-length start ignored
    @(posedge clk); #1; tx_start = 1'b1; tx_len = 7'd126;
    @(posedge clk); #1; tx_start = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(tx_valid === 1'b0, "R6 over-length ignored", tx_valid, 0);

    rx_frame(5, 6, 1'b0, 0);   // R9 R10 odd
    rx_frame(6, 7, 1'b0, 3);   // R8 junk before delimiter
    rx_frame(7, 8, 1'b1, 0);   // R10 corrupted check
    rx_frame(0, 9, 1'b0, 1);   // R10 empty payload
    rx_frame(125, 10, 1'b0, 0);
    begin  // R8 bad length drops back to search
      int d0;
      d0 = rx_done_cnt;
      rx_byte(8'hA7); rx_byte(8'h01);
      rx_byte(8'h11); rx_byte(8'h22); rx_byte(8'h33);
      repeat (3) @(posedge clk);
      chk(rx_done_cnt == d0, "R8 bad length no done", rx_done_cnt - d0, 0);
      rx_byte(8'hA7); rx_byte(8'hC8);
      repeat (3) @(posedge clk);
      chk(rx_done_cnt == d0, "R8 long length no done", rx_done_cnt - d0, 0);
    end
    rx_frame(3, 11, 1'b0, 0);  // R8 recovery

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule